// File: doc/BRIEF.md
# Cascaded Power-Up Sequencer

This block switches on a chain of three downstream power supplies one after another. Each link in the chain waits for the monitored rail of the stage before it to report valid. It then counts out a delay programmed for that link, and only then drives the next supply's enable. The rail-valid flags come from external threshold comparators. They are asynchronous to the block clock and are synchronized inside before use.

Four rail-valid flags are monitored and three active-low enables are driven. The first rail gates the first enable, the second rail gates the second enable, and the third rail gates the third enable. The fourth rail only contributes to the sequence-complete flag. Each link has its own 8-bit delay, counted in ticks of a parameterized clock prescaler.

A rail that drops while its own link is being timed clears that timer. A rail that drops after its link has already been sequenced collapses the whole chain back to the first stage.

Top module: `pwr_cascade_seq`

## Requirements
- R1: Enables assert only in the fixed order first, second, third. Enable k+1 is never active unless enable k is active, and enable k becomes active only when synchronized rail k was valid on the clock edge that set it.
- R2: A link's interval timer starts only on the first clock edge at which the synchronized flag of its upstream rail is seen valid. Time spent before that edge does not count toward the delay.
- R3: The delay of link k (enable k, 0 to 2) is `linkDelay[8k+7:8k]`. With a nonzero value D, the enable asserts D*PRESCALE clock edges after the timer start edge.
- R4: A delay value of zero asserts the enable on the clock edge at which the upstream rail is first seen valid. Counted from an input change applied between edges, this is the third rising edge.
- R5: If the rail being timed goes invalid before its link expires, the timer is cleared. Timing restarts from zero, at the full programmed length, once the rail is valid again.
- R6: If any rail whose link has already been sequenced (rail k with enable k active) goes invalid, all enables deassert and sequencing restarts from the first link. This collapse wins over a link expiry that falls on the same edge. A drop of the fourth rail does not deassert any enable.
- R7: While the synchronous reset `rst` is high, all enables are inactive, the completion flag is low and the synchronizers are cleared.
- R8: Each rail-valid input passes through a two-flop synchronizer, so the sequencer sees a change on the second rising edge after the input changes.
- R9: A link's delay is captured at its timer start edge. Changing `linkDelay` during an interval does not alter that interval, and the new value applies the next time the link starts.
- R10: `seqDone` is high exactly when all three enables are active and all four synchronized rails are valid.
- R11: Enables are active-low: `pupN[k]` is 0 when supply k is enabled and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| railValidIn | input | 4 | Asynchronous valid flags of the four monitored rails |
| linkDelay | input | 24 | Per-link delay in prescaled ticks, link k at bits 8k+7:8k |
| pupN | output | 3 | Active-low supply enables |
| seqDone | output | 1 | All enables active and all rails valid |

## Verification
Two events can fall on the same clock edge: a link's timer expiring, and an already-sequenced upstream rail dropping out. The bench provokes this by sweeping the moment rail 0 is removed across the whole interval of link 1, one cycle at a time, so that one sweep point lands exactly on the expiry edge. A behavioural reference model, compared on every clock, judges each point: it lets the collapse win and leaves no stray enable behind.

// File: rtl/pwr_cascade_pkg.sv
package pwr_cascade_pkg;

  localparam int LINKS = 3;
  localparam int RAILS = LINKS + 1;
  localparam int IDX_W = $clog2(LINKS + 1);

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_TIME = 2'd1,
    ST_FULL = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic             tmrLoad;
    logic             tmrRun;
    logic             tmrClear;
    logic             enSet;
    logic [IDX_W-1:0] enIdx;
    logic             enClrAll;
  } seq_strobe_t;

endpackage

// File: rtl/pwr_cascade_sync.sv
module pwr_cascade_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '0;
        else     pipe[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '0;
        else     pipe[g] <= pipe[g-1];
      end
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/pwr_cascade_dp.sv
module pwr_cascade_dp
  import pwr_cascade_pkg::*;
#(
  parameter int DLY_W    = 8,
  parameter int PRESCALE = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  seq_strobe_t            strobe,
  input  logic [IDX_W-1:0]       stageIdx,
  input  logic [LINKS*DLY_W-1:0] dlyCfg,
  output logic                   expired,
  output logic                   curDlyZero,
  output logic [LINKS-1:0]       enOut
);

  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [DLY_W-1:0] dlyArr [LINKS];
  logic [DLY_W-1:0] selDly;
  logic [DLY_W-1:0] latDly;
  logic [DLY_W-1:0] tickCnt;
  logic [PRE_W-1:0] preCnt;
  logic [LINKS-1:0] enReg;

  for (genvar g = 0; g < LINKS; g++) begin : g_dly
    assign dlyArr[g] = dlyCfg[g*DLY_W +: DLY_W];
  end

  always_comb begin
    selDly = '0;
    for (int k = 0; k < LINKS; k++) begin
      if (stageIdx == IDX_W'(k)) selDly = dlyArr[k];
    end
  end

  assign curDlyZero = (selDly == '0);
  assign expired    = (latDly != '0) && (tickCnt == latDly - 1'b1) && (preCnt == PRE_LAST);

  // Interval timer: prescaler plus tick counter against the captured delay
  always_ff @(posedge clk) begin
    if (rst || strobe.tmrClear) begin
      latDly  <= '0;
      tickCnt <= '0;
      preCnt  <= '0;
    end else if (strobe.tmrLoad) begin
      latDly  <= selDly;
      tickCnt <= '0;
      preCnt  <= '0;
    end else if (strobe.tmrRun) begin
      if (preCnt == PRE_LAST) begin
        preCnt  <= '0;
        tickCnt <= tickCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  // Enable register
  always_ff @(posedge clk) begin
    if (rst || strobe.enClrAll) begin
      enReg <= '0;
    end else if (strobe.enSet) begin
      for (int k = 0; k < LINKS; k++) begin
        if (strobe.enIdx == IDX_W'(k)) enReg[k] <= 1'b1;
      end
    end
  end

  assign enOut = enReg;

  // Tick count stays below the captured delay while an interval is held
  p_tick_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (latDly != '0) |-> (tickCnt < latDly));

  p_reset_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (enReg == '0));

  for (genvar g = 1; g < LINKS; g++) begin : g_order
    p_en_order_r1: assert property (@(posedge clk) disable iff (rst)
      enReg[g] |-> enReg[g-1]);
  end

endmodule

// File: rtl/pwr_cascade_ctrl.sv
module pwr_cascade_ctrl
  import pwr_cascade_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [RAILS-1:0] railOk,
  input  logic             expired,
  input  logic             curDlyZero,
  output seq_strobe_t      strobe,
  output logic [IDX_W-1:0] stage,
  output logic             seqDone
);

  seq_state_t       state, nxtState;
  logic [IDX_W-1:0] nxtStage;
  logic             fault;

  // A sequenced rail (below the current stage) has lost validity
  always_comb begin
    fault = 1'b0;
    for (int j = 0; j < LINKS; j++) begin
      if ((IDX_W'(j) < stage) && !railOk[j]) fault = 1'b1;
    end
  end

  always_comb begin
    strobe   = '0;
    nxtState = state;
    nxtStage = stage;
    if (fault) begin
      strobe.enClrAll = 1'b1;
      strobe.tmrClear = 1'b1;
      nxtStage        = '0;
      nxtState        = ST_WAIT;
    end else begin
      unique case (state)
        ST_WAIT: begin
          if (railOk[stage]) begin
            if (curDlyZero) begin
              strobe.enSet = 1'b1;
              strobe.enIdx = stage;
              nxtStage     = stage + 1'b1;
              nxtState     = (stage == IDX_W'(LINKS - 1)) ? ST_FULL : ST_WAIT;
            end else begin
              strobe.tmrLoad = 1'b1;
              nxtState       = ST_TIME;
            end
          end
        end
        ST_TIME: begin
          if (!railOk[stage]) begin
            strobe.tmrClear = 1'b1;
            nxtState        = ST_WAIT;
          end else if (expired) begin
            strobe.enSet    = 1'b1;
            strobe.enIdx    = stage;
            strobe.tmrClear = 1'b1;
            nxtStage        = stage + 1'b1;
            nxtState        = (stage == IDX_W'(LINKS - 1)) ? ST_FULL : ST_WAIT;
          end else begin
            strobe.tmrRun = 1'b1;
          end
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_WAIT;
      stage <= '0;
    end else begin
      state <= nxtState;
      stage <= nxtStage;
    end
  end

  assign seqDone = (state == ST_FULL) && (&railOk);

  p_restart_r6: assert property (@(posedge clk) disable iff (rst)
    fault |=> (stage == '0) && (state == ST_WAIT));

  p_full_stage_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FULL) |-> (stage == IDX_W'(LINKS)));

  p_timed_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TIME && !railOk[stage] && !fault) |=> (state == ST_WAIT));

endmodule

// File: rtl/pwr_cascade_seq.sv
module pwr_cascade_seq
  import pwr_cascade_pkg::*;
#(
  parameter int DLY_W    = 8,
  parameter int PRESCALE = 4,
  parameter int SYNC_N   = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [RAILS-1:0]       railValidIn,
  input  logic [LINKS*DLY_W-1:0] linkDelay,
  output logic [LINKS-1:0]       pupN,
  output logic                   seqDone
);

  logic [RAILS-1:0] railOk;
  seq_strobe_t      strobe;
  logic [IDX_W-1:0] stage;
  logic             expired;
  logic             curDlyZero;
  logic [LINKS-1:0] enOut;

  pwr_cascade_sync #(.WIDTH(RAILS), .STAGES(SYNC_N)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (railValidIn),
    .dout (railOk)
  );

  pwr_cascade_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .railOk     (railOk),
    .expired    (expired),
    .curDlyZero (curDlyZero),
    .strobe     (strobe),
    .stage      (stage),
    .seqDone    (seqDone)
  );

  pwr_cascade_dp #(.DLY_W(DLY_W), .PRESCALE(PRESCALE)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .stageIdx   (stage),
    .dlyCfg     (linkDelay),
    .expired    (expired),
    .curDlyZero (curDlyZero),
    .enOut      (enOut)
  );

  assign pupN = ~enOut;

  for (genvar g = 0; g < LINKS; g++) begin : g_gate
    p_rise_gated_r1: assert property (@(posedge clk) disable iff (rst)
      (!pupN[g] && $past(pupN[g])) |-> $past(railOk[g]));
  end

  p_done_all_on_r10: assert property (@(posedge clk) disable iff (rst)
    seqDone |-> (pupN == '0));

endmodule

// File: tb/pwr_cascade_seq_bench.sv
module pwr_cascade_seq_bench;

  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  railValid = 4'b0;
  logic [23:0] linkDelay = 24'h0;
  logic [2:0]  pupN;
  logic        seqDone;

  int    testCnt = 0;
  int    failCnt = 0;
  string curReq  = "R7";

  always #2 clk = ~clk;

  pwr_cascade_seq #(.DLY_W(8), .PRESCALE(P), .SYNC_N(2)) u_pwr_cascade_seq (
    .clk         (clk),
    .rst         (rst),
    .railValidIn (railValid),
    .linkDelay   (linkDelay),
    .pupN        (pupN),
    .seqDone     (seqDone)
  );

  // Behavioural reference model
  int         mStage   = 0;
  bit         mTiming  = 0;
  int         mElapsed = 0;
  int         mLat     = 0;
  logic [3:0] mS1 = 4'b0;
  logic [3:0] mS2 = 4'b0;

  always @(posedge clk) begin
    logic [3:0] v;
    bit         flt;
    v   = mS2;
    flt = 0;
    if (rst) begin
      mStage = 0; mTiming = 0; mElapsed = 0; mS1 = 4'b0; mS2 = 4'b0;
    end else begin
      for (int j = 0; j < 3; j++) if (j < mStage && !v[j]) flt = 1;
      if (flt) begin
        mStage = 0; mTiming = 0;
      end else if (mStage < 3) begin
        if (!mTiming) begin
          if (v[mStage]) begin
            mLat = int'(linkDelay[mStage*8 +: 8]);
            if (mLat == 0) mStage++;
            else begin mTiming = 1; mElapsed = 0; end
          end
        end else if (!v[mStage]) begin
          mTiming = 0;
        end else begin
          mElapsed++;
          if (mElapsed == mLat * P) begin mStage++; mTiming = 0; end
        end
      end
      mS2 = mS1;
      mS1 = railValid;
    end
  end

  task automatic check(string req, int act, int exp, string what);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    logic [2:0] expPup;
    expPup = 3'b111;
    for (int i = 0; i < 3; i++) if (mStage > i) expPup[i] = 1'b0;
    check(curReq, int'(pupN), int'(expPup), "pupN vs model");
    check(curReq, int'(seqDone), int'(mStage == 3 && (&mS2)), "seqDone vs model");
  end

  task automatic resetDut();
    rst = 1'b1;
    railValid = 4'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic measure(int idx, output int n);
    n = 0;
    while (pupN[idx] !== 1'b0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin : main
    int n;
    // R7, R11: reset state
    curReq = "R7";
    resetDut();
    check("R11", int'(pupN), 7, "enables inactive (high) after reset");
    check("R7", int'(seqDone), 0, "done low after reset");

    // R3, R8: per-link delays, links 0/1/2 with 3,2,5 ticks
    curReq = "R3";
    linkDelay = {8'd5, 8'd2, 8'd3};
    railValid = 4'b0001;
    measure(0, n);
    check("R8", n, 3 + 3 * P, "link0 latency in edges");
    railValid = 4'b0011;
    measure(1, n);
    check("R3", n, 3 + 2 * P, "link1 latency in edges");
    railValid = 4'b0111;
    measure(2, n);
    check("R3", n, 3 + 5 * P, "link2 latency in edges");
    curReq = "R10";
    repeat (2) @(negedge clk);
    check("R10", int'(seqDone), 0, "done low while rail3 invalid");
    railValid = 4'b1111;
    repeat (3) @(negedge clk);
    check("R10", int'(seqDone), 1, "done high with all rails valid");
    check("R11", int'(pupN), 0, "all enables low when active");

    // R6: fourth rail drop keeps enables, clears done
    curReq = "R6";
    railValid = 4'b0111;
    repeat (4) @(negedge clk);
    check("R6", int'(pupN), 0, "rail3 drop leaves enables on");
    check("R10", int'(seqDone), 0, "rail3 drop clears done");
    // R6: sequenced rail drop collapses chain
    railValid = 4'b1110;
    repeat (4) @(negedge clk);
    check("R6", int'(pupN), 7, "rail0 drop collapses all enables");

    // R7: reset mid-sequence
    curReq = "R7";
    railValid = 4'b0001;
    linkDelay = 24'h010101;
    repeat (6) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R7", int'(pupN), 7, "sync reset drops enables");
    rst = 1'b0;

    // R4: zero delay
    curReq = "R4";
    resetDut();
    linkDelay = {8'd0, 8'd0, 8'd0};
    railValid = 4'b0001;
    measure(0, n);
    check("R4", n, 3, "zero delay link0");
    railValid = 4'b0011;
    measure(1, n);
    check("R4", n, 3, "zero delay link1");

    // R2: downstream rails valid before rail0; nothing may enable
    curReq = "R2";
    resetDut();
    linkDelay = {8'd1, 8'd1, 8'd1};
    railValid = 4'b1110;
    repeat (40) @(negedge clk);
    check("R2", int'(pupN), 7, "no enable without rail0");
    railValid = 4'b1111;
    measure(0, n);
    check("R2", n, 3 + P, "timer counts only from rail0 validity");

    // R5: timed rail glitch clears timer
    curReq = "R5";
    resetDut();
    linkDelay = {8'd1, 8'd2, 8'd0};
    railValid = 4'b0001;
    measure(0, n);
    railValid = 4'b0011;
    repeat (5) @(negedge clk);
    railValid = 4'b0001;
    repeat (2) @(negedge clk);
    railValid = 4'b0011;
    measure(1, n);
    check("R5", n, 3 + 2 * P, "timer restarts from zero after drop");

    // R9: delay change during interval ignored until next start
    curReq = "R9";
    resetDut();
    linkDelay = {8'd1, 8'd1, 8'd4};
    railValid = 4'b0001;
    repeat (5) @(negedge clk);
    linkDelay = {8'd1, 8'd1, 8'd1};
    n = 0;
    while (pupN[0] !== 1'b0 && n < 3000) begin @(negedge clk); n++; end
    check("R9", n + 5, 3 + 4 * P, "mid-interval write ignored");
    railValid = 4'b0000;
    repeat (4) @(negedge clk);
    railValid = 4'b0001;
    measure(0, n);
    check("R9", n, 3 + P, "new delay applies next sequence");

    // R6 vs R3 expiry: sweep rail0 loss across link1 interval
    curReq = "R6";
    for (int off = 0; off <= 2 * P + 5; off++) begin
      resetDut();
      linkDelay = {8'd1, 8'd2, 8'd0};
      railValid = 4'b0001;
      measure(0, n);
      railValid = 4'b0011;
      repeat (off) @(negedge clk);
      railValid = 4'b0010;
      repeat (5) @(negedge clk);
      check("R6", int'(pupN), 7, "collapse after upstream loss");
    end

    curReq = "R1";
    resetDut();
    check("R1", int'(pupN), 7, "order restart state");

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule